// File: doc/BRIEF.md
# Demand-Paged Address Translator with TLB

This block translates 8-bit byte addresses of a small machine into 7-bit physical addresses. The upper four address bits select one of 16 virtual pages of 16 bytes. Physical memory holds eight 16-byte frames. One of those frames is reserved for the page table and is never handed to a page. Each request is looked up first in a three-entry fully associative translation cache, then in the page table. If both miss, a page fault brings the page into a frame.

Every request yields a registered result one cycle later. The result carries a result code (translation-cache hit, table hit or fault), the physical address, and two running counters: translation-cache hits and faults. Two recency orders are kept. One ranks the translation-cache slots and picks the slot to refill. The other ranks the physical frames and picks the page to evict once no empty frame is left.

When a fault evicts a page that still has a translation-cache entry, that entry is dropped in the same cycle, and its slot takes the new page. A configuration port, honoured only in cycles without a request, preloads page-table mappings and translation-cache slots after reset.

Top module: `tlb_pager`

## Requirements
- R1: After reset, no response is flagged, both counters read 0, no page is mapped and all translation-cache slots are empty. Frame 0 is the least recent frame and slot 0 is the least recent slot.
- R2: A request in one cycle gives rsp_valid=1 in the next cycle, with a nonzero rsp_code and rsp_paddr = {frame, offset}, the offset being vaddr[3:0]. Without a request, rsp_valid is 0 and the counters hold. The result codes are 1 = translation-cache hit, 2 = table hit, 3 = page fault.
- R3: A page held in a valid translation-cache slot gives code 1 and that slot's frame, and hit_cnt rises by one.
- R4: A page that is mapped in the table but absent from the translation cache gives code 2. Its mapping is then written into the lowest-index empty slot, or into the least recently used slot if none is empty.
- R5: An unmapped page gives code 3 and fault_cnt rises by one. The page goes into the lowest-index empty frame, not counting the reserved frame.
- R6: When all non-reserved frames are full, a fault evicts the least recently referenced resident page and reuses its frame. The evicted page faults again on its next reference.
- R7: Frame 7, the reserved page-table frame, is never given to a page, and a configuration mapping that targets it is ignored.
- R8: If the evicted page has a translation-cache entry, that entry is removed in the same cycle and its slot receives the faulting page. The other slots are left intact.
- R9: Every reference, including a translation-cache hit, makes its frame the most recent. Hits, refills and configuration writes make the slot concerned the most recent.
- R10: When req_valid is low, cfg_pt_we maps cfg_pt_vpn to cfg_pt_frame, and cfg_tlb_we loads a slot and makes it the most recent. Both are ignored in a cycle with a request.
- R11: Starting from a translation cache holding pages 0, 2 and 13, the reference string 0,13,5,2,14,14,13,6,6,13,15,14,15,13,4,3 gives 7 translation-cache hits. Pages 4, 13 and 3 are cached afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | 8 | Virtual byte address |
| cfg_pt_we | input | 1 | Write a page-table mapping |
| cfg_pt_vpn | input | 4 | Page for the mapping |
| cfg_pt_frame | input | 3 | Frame for the mapping |
| cfg_tlb_we | input | 1 | Load a translation-cache slot |
| cfg_tlb_slot | input | 2 | Slot to load |
| cfg_tlb_vpn | input | 4 | Page held by the slot |
| cfg_tlb_frame | input | 3 | Frame held by the slot |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 1 cache hit, 2 table hit, 3 fault |
| rsp_paddr | output | 7 | Physical address |
| hit_cnt | output | 16 | Running translation-cache hit count |
| fault_cnt | output | 16 | Running page fault count |

## Verification
A page eviction and the translation-cache refill can fall in the same cycle when the evicted page is still cached. This happens only if that page was preloaded through configuration and has not been referenced since. The bench sets this up by mapping all seven usable frames and loading stale cache slots in an order that makes a different slot the least recent. It then faults a new page. The result is judged at the ports: the new page must hit in the cache afterwards, the untouched slot's page must still hit, and the evicted page must fault. Randomly configured rounds repeat this against a bench model that keeps timestamps for recency.

// File: rtl/tlb_pager_pkg.sv
// Package: shared result encoding for the address translator.
package tlb_pager_pkg;
    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_TLB_HIT = 2'd1,
        RES_PT_HIT  = 2'd2,
        RES_FAULT   = 2'd3
    } res_e;
endpackage

// File: rtl/tlb_lru_rank.sv
// Recency ranking over N entries. Rank 0 is most recent, rank N-1 least.
// Assumes touch_idx < N. Victim is the eligible entry with highest rank.
// After reset entry 0 is least recent.
module tlb_lru_rank #(
    parameter int N = 3,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         touch,
    input  logic [W-1:0] touch_idx,
    input  logic [N-1:0] elig,
    output logic [W-1:0] victim
);
    logic [W-1:0] rank [N];
    logic [W-1:0] best;
    logic         found;

    // Move the touched entry to rank 0 and age those that were more recent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank[i] <= W'(N - 1 - i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (W'(i) == touch_idx) rank[i] <= '0;
                else if (rank[i] < rank[touch_idx]) rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    // Pick the eligible entry with the oldest rank.
    always_comb begin
        victim = '0;
        best   = '0;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || rank[i] > best)) begin
                victim = W'(i);
                best   = rank[i];
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_cam.sv
// Fully associative translation cache storage with two match ports:
// one for the request page, one probing for the page being evicted.
// Assumes at most one valid slot per page (maintained by the top).
module tlb_cam #(
    parameter int N      = 3,
    parameter int VPN_W  = 4,
    parameter int FRM_W  = 3,
    parameter int SLOT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VPN_W-1:0]     look_vpn,
    output logic                 look_hit,
    output logic [SLOT_W-1:0]    look_idx,
    output logic [FRM_W-1:0]     look_frm,
    input  logic [VPN_W-1:0]     probe_vpn,
    output logic                 probe_hit,
    output logic [SLOT_W-1:0]    probe_idx,
    output logic                 any_free,
    output logic [SLOT_W-1:0]    free_idx,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_idx,
    input  logic [VPN_W-1:0]     wr_vpn,
    input  logic [FRM_W-1:0]     wr_frm,
    output logic [N-1:0]         vld_o,
    output logic [N*VPN_W-1:0]   vpn_flat
);
    logic [N-1:0]     vld;
    logic [VPN_W-1:0] vpn [N];
    logic [FRM_W-1:0] frm [N];

    // Slot write: a refill or configuration load marks the slot valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < N; i++) begin
                vpn[i] <= '0;
                frm[i] <= '0;
            end
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
            vpn[wr_idx] <= wr_vpn;
            frm[wr_idx] <= wr_frm;
        end
    end

    // Match both ports and find the lowest empty slot.
    always_comb begin
        look_hit  = 1'b0;
        look_idx  = '0;
        look_frm  = '0;
        probe_hit = 1'b0;
        probe_idx = '0;
        any_free  = 1'b0;
        free_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vld[i] && vpn[i] == look_vpn) begin
                look_hit = 1'b1;
                look_idx = SLOT_W'(i);
                look_frm = frm[i];
            end
            if (vld[i] && vpn[i] == probe_vpn) begin
                probe_hit = 1'b1;
                probe_idx = SLOT_W'(i);
            end
            if (!vld[i]) begin
                any_free = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end

    // Flatten slot pages for the checker.
    always_comb begin
        for (int i = 0; i < N; i++) vpn_flat[i*VPN_W +: VPN_W] = vpn[i];
    end
    assign vld_o = vld;
endmodule

// File: rtl/tlb_page_store.sv
// One-level page table plus reverse frame ownership map.
// Mapping a page into an owned frame unmaps the previous owner.
// The pinned frame is never mapped. Assumes a page is not remapped
// while already mapped elsewhere.
module tlb_page_store #(
    parameter int VPN_W = 4,
    parameter int FRM_W = 3,
    parameter int PIN   = 7,
    localparam int NP   = 1 << VPN_W,
    localparam int NF   = 1 << FRM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             pt_hit,
    output logic [FRM_W-1:0] pt_frm,
    input  logic [FRM_W-1:0] owner_frm,
    output logic [VPN_W-1:0] owner_vpn,
    output logic             free_found,
    output logic [FRM_W-1:0] free_idx,
    output logic [NF-1:0]    used_o,
    input  logic             map_en,
    input  logic [VPN_W-1:0] map_vpn,
    input  logic [FRM_W-1:0] map_frm
);
    logic [NP-1:0]    pt_v;
    logic [FRM_W-1:0] pt_f [NP];
    logic [NF-1:0]    fr_used;
    logic [VPN_W-1:0] fr_pg [NF];

    // Install a mapping, dropping the frame's previous owner first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_v    <= '0;
            fr_used <= '0;
            for (int i = 0; i < NP; i++) pt_f[i] <= '0;
            for (int i = 0; i < NF; i++) fr_pg[i] <= '0;
        end else if (map_en && map_frm != FRM_W'(PIN)) begin
            if (fr_used[map_frm]) pt_v[fr_pg[map_frm]] <= 1'b0;
            pt_v[map_vpn]    <= 1'b1;
            pt_f[map_vpn]    <= map_frm;
            fr_used[map_frm] <= 1'b1;
            fr_pg[map_frm]   <= map_vpn;
        end
    end

    assign pt_hit    = pt_v[look_vpn];
    assign pt_frm    = pt_f[look_vpn];
    assign owner_vpn = fr_pg[owner_frm];
    assign used_o    = fr_used;

    // Lowest empty frame, skipping the pinned one.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = NF - 1; i >= 0; i--) begin
            if (!fr_used[i] && i != PIN) begin
                free_found = 1'b1;
                free_idx   = FRM_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_pager.sv
// Top: translates page references through a small fully associative cache
// backed by a one-level table, faulting pages in with recency eviction.
// One request per cycle, result registered one cycle later. Configuration
// writes apply only in cycles with no request.
module tlb_pager
    import tlb_pager_pkg::*;
#(
    parameter int VPN_W    = 4,
    parameter int OFF_W    = 4,
    parameter int FRM_W    = 3,
    parameter int TLB_N    = 3,
    parameter int PT_FRAME = 7,
    parameter int CNT_W    = 16,
    localparam int VA_W    = VPN_W + OFF_W,
    localparam int PA_W    = FRM_W + OFF_W,
    localparam int NF      = 1 << FRM_W,
    localparam int SLOT_W  = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              cfg_pt_we,
    input  logic [VPN_W-1:0]  cfg_pt_vpn,
    input  logic [FRM_W-1:0]  cfg_pt_frame,
    input  logic              cfg_tlb_we,
    input  logic [SLOT_W-1:0] cfg_tlb_slot,
    input  logic [VPN_W-1:0]  cfg_tlb_vpn,
    input  logic [FRM_W-1:0]  cfg_tlb_frame,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  fault_cnt
);
    logic [VPN_W-1:0]  vpn;
    logic [OFF_W-1:0]  off;
    logic              t_hit, p_hit, probe_hit, t_any_free, free_found;
    logic [SLOT_W-1:0] t_idx, probe_idx, t_free_idx, t_lru_idx, fill_idx;
    logic [FRM_W-1:0]  t_frm, p_frm, free_frm, lru_frm, new_frm, use_frm;
    logic [VPN_W-1:0]  evict_vpn;
    logic [NF-1:0]     fr_used;
    logic [TLB_N-1:0]  tlb_vld;
    logic [TLB_N*VPN_W-1:0] tlb_vpn_flat;
    logic              fault, evict, cfg_ok, cfg_tlb_ok;
    logic              tlb_wr, map_en, tlb_touch;
    logic [SLOT_W-1:0] tlb_wr_idx, tlb_touch_idx;
    logic [VPN_W-1:0]  tlb_wr_vpn, map_vpn;
    logic [FRM_W-1:0]  tlb_wr_frm, map_frm;
    res_e              res;

    assign vpn = req_vaddr[VA_W-1:OFF_W];
    assign off = req_vaddr[OFF_W-1:0];

    tlb_cam #(.N(TLB_N), .VPN_W(VPN_W), .FRM_W(FRM_W), .SLOT_W(SLOT_W)) u_cam (
        .clk(clk), .rst_n(rst_n),
        .look_vpn(vpn), .look_hit(t_hit), .look_idx(t_idx), .look_frm(t_frm),
        .probe_vpn(evict_vpn), .probe_hit(probe_hit), .probe_idx(probe_idx),
        .any_free(t_any_free), .free_idx(t_free_idx),
        .wr_en(tlb_wr), .wr_idx(tlb_wr_idx), .wr_vpn(tlb_wr_vpn), .wr_frm(tlb_wr_frm),
        .vld_o(tlb_vld), .vpn_flat(tlb_vpn_flat)
    );

    tlb_page_store #(.VPN_W(VPN_W), .FRM_W(FRM_W), .PIN(PT_FRAME)) u_store (
        .clk(clk), .rst_n(rst_n),
        .look_vpn(vpn), .pt_hit(p_hit), .pt_frm(p_frm),
        .owner_frm(new_frm), .owner_vpn(evict_vpn),
        .free_found(free_found), .free_idx(free_frm), .used_o(fr_used),
        .map_en(map_en), .map_vpn(map_vpn), .map_frm(map_frm)
    );

    tlb_lru_rank #(.N(TLB_N), .W(SLOT_W)) u_tlb_lru (
        .clk(clk), .rst_n(rst_n), .touch(tlb_touch), .touch_idx(tlb_touch_idx),
        .elig({TLB_N{1'b1}}), .victim(t_lru_idx)
    );

    tlb_lru_rank #(.N(NF), .W(FRM_W)) u_frm_lru (
        .clk(clk), .rst_n(rst_n), .touch(req_valid), .touch_idx(use_frm),
        .elig(fr_used & ~(NF'(1) << PT_FRAME)), .victim(lru_frm)
    );

    // Classify the request and choose frame and cache slot.
    always_comb begin
        fault   = !t_hit && !p_hit;
        new_frm = free_found ? free_frm : lru_frm;
        evict   = fault && !free_found;
        if (t_hit)      use_frm = t_frm;
        else if (p_hit) use_frm = p_frm;
        else            use_frm = new_frm;
        if (evict && probe_hit) fill_idx = probe_idx;
        else if (t_any_free)    fill_idx = t_free_idx;
        else                    fill_idx = t_lru_idx;
        if (t_hit)      res = RES_TLB_HIT;
        else if (p_hit) res = RES_PT_HIT;
        else            res = RES_FAULT;
    end

    // Steer write ports between request traffic and configuration.
    always_comb begin
        cfg_ok     = !req_valid;
        cfg_tlb_ok = cfg_ok && cfg_tlb_we && (int'(cfg_tlb_slot) < TLB_N);
        tlb_wr     = (req_valid && !t_hit) || cfg_tlb_ok;
        tlb_wr_idx = req_valid ? fill_idx : cfg_tlb_slot;
        tlb_wr_vpn = req_valid ? vpn : cfg_tlb_vpn;
        tlb_wr_frm = req_valid ? use_frm : cfg_tlb_frame;
        tlb_touch     = req_valid || cfg_tlb_ok;
        tlb_touch_idx = req_valid ? (t_hit ? t_idx : fill_idx) : cfg_tlb_slot;
        map_en  = (req_valid && fault) || (cfg_ok && cfg_pt_we);
        map_vpn = req_valid ? vpn : cfg_pt_vpn;
        map_frm = req_valid ? new_frm : cfg_pt_frame;
    end

    // Register the response and advance the counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RES_NONE;
            rsp_paddr <= '0;
            hit_cnt   <= '0;
            fault_cnt <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_code  <= res;
                rsp_paddr <= {use_frm, off};
                if (t_hit) hit_cnt   <= hit_cnt + 1'b1;
                if (fault) fault_cnt <= fault_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_pager_chk.sv
// Checker bound to tlb_pager: port-level timing, counter, pinned-frame
// and cache-uniqueness properties.
module tlb_pager_chk #(
    parameter int VPN_W    = 4,
    parameter int FRM_W    = 3,
    parameter int OFF_W    = 4,
    parameter int TLB_N    = 3,
    parameter int PT_FRAME = 7,
    parameter int CNT_W    = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    rsp_valid,
    input logic [1:0]              rsp_code,
    input logic [FRM_W+OFF_W-1:0]  rsp_paddr,
    input logic [CNT_W-1:0]        hit_cnt,
    input logic [CNT_W-1:0]        fault_cnt,
    input logic [TLB_N-1:0]        tlb_vld,
    input logic [TLB_N*VPN_W-1:0]  tlb_vpn_flat
);
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_code_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_code != 2'd0);
    assert_hit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd1) |-> hit_cnt == $past(hit_cnt) + 1'b1);
    assert_fault_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd3) |-> fault_cnt == $past(fault_cnt) + 1'b1);
    assert_counts_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($stable(hit_cnt) && $stable(fault_cnt)));
    assert_pinned_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_paddr[FRM_W+OFF_W-1:OFF_W] != FRM_W'(PT_FRAME));

    // R8: an eviction never leaves two slots for one page.
    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < TLB_N; i++) begin
                for (int j = i + 1; j < TLB_N; j++) begin
                    assert_tlb_unique_R8: assert (!(tlb_vld[i] && tlb_vld[j] &&
                        tlb_vpn_flat[i*VPN_W +: VPN_W] == tlb_vpn_flat[j*VPN_W +: VPN_W]))
                        else $error("duplicate cache slot page");
                end
            end
        end
    end
endmodule

bind tlb_pager tlb_pager_chk #(
    .VPN_W(VPN_W), .FRM_W(FRM_W), .OFF_W(OFF_W), .TLB_N(TLB_N),
    .PT_FRAME(PT_FRAME), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .hit_cnt(hit_cnt),
    .fault_cnt(fault_cnt), .tlb_vld(tlb_vld), .tlb_vpn_flat(tlb_vpn_flat)
);

// File: tb/tlb_pager_bench.sv
// Bench: directed corner cases plus seeded random rounds, checked against
// a timestamp-based reference model.
module tlb_pager_bench;
    localparam int PIN = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_vaddr = '0;
    logic       cfg_pt_we = 1'b0;
    logic [3:0] cfg_pt_vpn = '0;
    logic [2:0] cfg_pt_frame = '0;
    logic       cfg_tlb_we = 1'b0;
    logic [1:0] cfg_tlb_slot = '0;
    logic [3:0] cfg_tlb_vpn = '0;
    logic [2:0] cfg_tlb_frame = '0;
    logic       rsp_valid;
    logic [1:0] rsp_code;
    logic [6:0] rsp_paddr;
    logic [15:0] hit_cnt, fault_cnt;

    tlb_pager u_tlb_pager (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .cfg_pt_we(cfg_pt_we), .cfg_pt_vpn(cfg_pt_vpn), .cfg_pt_frame(cfg_pt_frame),
        .cfg_tlb_we(cfg_tlb_we), .cfg_tlb_slot(cfg_tlb_slot), .cfg_tlb_vpn(cfg_tlb_vpn),
        .cfg_tlb_frame(cfg_tlb_frame), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_paddr(rsp_paddr), .hit_cnt(hit_cnt), .fault_cnt(fault_cnt)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Reference model state.
    int m_pv[16], m_pf[16], m_fu[8], m_fp[8], m_ft[8];
    int m_tv[3], m_tp[3], m_tf[3], m_tt[3];
    int now, m_hits, m_faults;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void mdl_reset();
        for (int i = 0; i < 16; i++) begin m_pv[i] = 0; m_pf[i] = 0; end
        for (int i = 0; i < 8; i++) begin m_fu[i] = 0; m_fp[i] = 0; m_ft[i] = i; end
        for (int i = 0; i < 3; i++) begin m_tv[i] = 0; m_tp[i] = 0; m_tf[i] = 0; m_tt[i] = i; end
        now = 16; m_hits = 0; m_faults = 0;
    endfunction

    function automatic void mdl_map(input int v, input int f);
        if (f == PIN) return;
        if (m_fu[f] != 0) m_pv[m_fp[f]] = 0;
        m_pv[v] = 1; m_pf[v] = f; m_fu[f] = 1; m_fp[f] = v;
    endfunction

    function automatic void mdl_fill(input int freed, input int v, input int f);
        int s;
        s = -1;
        if (freed >= 0) s = freed;
        else begin
            for (int i = 2; i >= 0; i--) if (m_tv[i] == 0) s = i;
            if (s < 0) begin
                s = 0;
                for (int i = 1; i < 3; i++) if (m_tt[i] < m_tt[s]) s = i;
            end
        end
        m_tv[s] = 1; m_tp[s] = v; m_tf[s] = f; m_tt[s] = now;
    endfunction

    function automatic void mdl_ref(input int v, output int code, output int frm);
        int hs, f, freed;
        hs = -1;
        for (int i = 0; i < 3; i++) if (m_tv[i] != 0 && m_tp[i] == v) hs = i;
        if (hs >= 0) begin
            code = 1; frm = m_tf[hs]; m_tt[hs] = now;
            m_hits = (m_hits + 1) & 16'hFFFF;
        end else if (m_pv[v] != 0) begin
            code = 2; frm = m_pf[v];
            mdl_fill(-1, v, frm);
        end else begin
            code = 3; f = -1; freed = -1;
            for (int i = 7; i >= 0; i--) if (i != PIN && m_fu[i] == 0) f = i;
            if (f < 0) begin
                for (int i = 0; i < 8; i++)
                    if (i != PIN && (f < 0 || m_ft[i] < m_ft[f])) f = i;
                for (int i = 0; i < 3; i++)
                    if (m_tv[i] != 0 && m_tp[i] == m_fp[f]) freed = i;
            end
            mdl_map(v, f);
            frm = f;
            mdl_fill(freed, v, f);
            m_faults = (m_faults + 1) & 16'hFFFF;
        end
        m_ft[frm] = now;
        now++;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; cfg_pt_we = 1'b0; cfg_tlb_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdl_reset();
    endtask

    task automatic cfg_pt(input int v, input int f);
        cfg_pt_we = 1'b1; cfg_pt_vpn = 4'(v); cfg_pt_frame = 3'(f);
        @(negedge clk);
        cfg_pt_we = 1'b0;
        mdl_map(v, f);
    endtask

    task automatic cfg_tlb(input int s, input int v, input int f);
        cfg_tlb_we = 1'b1; cfg_tlb_slot = 2'(s); cfg_tlb_vpn = 4'(v); cfg_tlb_frame = 3'(f);
        @(negedge clk);
        cfg_tlb_we = 1'b0;
        m_tv[s] = 1; m_tp[s] = v; m_tf[s] = f; m_tt[s] = now; now++;
    endtask

    // Issue one reference at a falling edge; check at the next falling edge.
    task automatic do_ref(input int v, input int o, input string tag, output int code);
        int frm;
        req_valid = 1'b1; req_vaddr = 8'((v << 4) | o);
        mdl_ref(v, code, frm);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, tag, "rsp_valid", int'(rsp_valid), 1);
        chk(int'(rsp_code) == code, tag, "rsp_code", int'(rsp_code), code);
        chk(int'(rsp_paddr) == frm * 16 + o, tag, "rsp_paddr", int'(rsp_paddr), frm * 16 + o);
        chk(int'(hit_cnt) == m_hits, tag, "hit_cnt", int'(hit_cnt), m_hits);
        chk(int'(fault_cnt) == m_faults, tag, "fault_cnt", int'(fault_cnt), m_faults);
    endtask

    task automatic expect_code(input int v, input int exp, input string tag);
        int c;
        do_ref(v, 5, tag, c);
        chk(c == exp, tag, "model code", c, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int c;
        int seq[16] = '{0,13,5,2,14,14,13,6,6,13,15,14,15,13,4,3};
        void'($urandom(32'd4711));

        // R1: reset state
        do_reset();
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
        chk(hit_cnt == 16'd0, "R1", "hit_cnt", int'(hit_cnt), 0);
        chk(fault_cnt == 16'd0, "R1", "fault_cnt", int'(fault_cnt), 0);
        expect_code(5, 3, "R1");  // nothing mapped: fault into frame 0
        // R2: idle cycle drops rsp_valid and holds counters
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "idle rsp_valid", int'(rsp_valid), 0);
        chk(fault_cnt == 16'd1, "R2", "idle fault_cnt", int'(fault_cnt), 1);

        // R11: worked reference string
        do_reset();
        cfg_pt(13, 1); cfg_pt(5, 2); cfg_pt(2, 3); cfg_pt(0, 5);
        cfg_tlb(0, 0, 5); cfg_tlb(1, 2, 3); cfg_tlb(2, 13, 1);
        for (int i = 0; i < 16; i++) do_ref(seq[i], i & 15, "R11", c);
        chk(hit_cnt == 16'd7, "R11", "hits of 16", int'(hit_cnt), 7);
        chk(fault_cnt == 16'd5, "R11", "faults of 16", int'(fault_cnt), 5);
        expect_code(4, 1, "R11");
        expect_code(13, 1, "R11");
        expect_code(3, 1, "R11");

        // R7 / R10: pinned-frame mapping and writes during a request are ignored
        do_reset();
        cfg_pt(9, 7);
        expect_code(9, 3, "R7");
        req_valid = 1'b1; req_vaddr = 8'h31;
        cfg_pt_we = 1'b1; cfg_pt_vpn = 4'd3; cfg_pt_frame = 3'd4;
        cfg_tlb_we = 1'b1; cfg_tlb_slot = 2'd1; cfg_tlb_vpn = 4'd3; cfg_tlb_frame = 3'd4;
        mdl_ref(3, c, c);
        @(negedge clk);
        req_valid = 1'b0; cfg_pt_we = 1'b0; cfg_tlb_we = 1'b0;
        chk(rsp_code == 2'd3, "R10", "code with cfg", int'(rsp_code), 3);
        chk(rsp_paddr == 7'h11, "R10", "paddr with cfg", int'(rsp_paddr), 7'h11);
        expect_code(3, 1, "R10");
        expect_code(4, 3, "R5");

        // R9 / R6: cache hits refresh frame recency
        do_reset();
        for (int p = 0; p <= 6; p++) expect_code(p, 3, "R5");
        expect_code(0, 2, "R4"); expect_code(1, 2, "R4");
        expect_code(6, 1, "R9");
        for (int p = 2; p <= 5; p++) expect_code(p, 2, "R4");
        do_ref(8, 2, "R9", c);
        chk(rsp_paddr[6:4] == 3'd0, "R9", "evicted frame", int'(rsp_paddr[6:4]), 0);
        expect_code(0, 3, "R6");

        // R8: eviction of a stale cached page refills its own slot
        do_reset();
        for (int p = 0; p <= 6; p++) cfg_pt(p, p);
        cfg_tlb(0, 2, 2); cfg_tlb(1, 1, 1); cfg_tlb(2, 0, 0);
        do_ref(8, 0, "R8", c);
        chk(rsp_paddr[6:4] == 3'd0, "R8", "fault frame", int'(rsp_paddr[6:4]), 0);
        expect_code(2, 1, "R8");
        expect_code(8, 1, "R8");
        expect_code(0, 3, "R8");

        // Random rounds: R3 R4 R5 R6 R8 R9 against the model
        for (int r = 0; r < 6; r++) begin
            do_reset();
            for (int f = 0; f < 7; f++) begin
                if ($urandom % 2 == 1) begin
                    int v;
                    v = $urandom % 16;
                    while (m_pv[v] != 0) v = (v + 1) % 16;
                    cfg_pt(v, f);
                end
            end
            for (int s = 0; s < 3; s++) begin
                int f;
                f = $urandom % 7;
                if (m_fu[f] != 0 && !(m_tv[0] && m_tp[0] == m_fp[f]) &&
                    !(m_tv[1] && m_tp[1] == m_fp[f]) && !(m_tv[2] && m_tp[2] == m_fp[f]))
                    cfg_tlb(s, m_fp[f], f);
            end
            for (int k = 0; k < 400; k++) begin
                int v;
                v = ($urandom % 4 == 0) ? $urandom % 16 : $urandom % 9;
                do_ref(v, $urandom % 16, "R3_R4_R5_R6", c);
                if ($urandom % 8 == 0) @(negedge clk);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule